// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns a 12-bit operand address into a physical word address. It also decides whether the access goes to erasable memory (RAM) or fixed memory (ROM). The top two address bits choose the region. Within erasable space, the next two bits choose between three unswitched banks and one window. A 3-bit erasable bank register steers that window. A second window, steered by a 5-bit fixed bank register, opens onto fixed memory. The upper half of the address space maps straight onto fixed memory with no bank register involved.

The bank registers sit at mapped register addresses:

| Register | Address | Field |
|---|---|---|
| Erasable bank | 3 | bits 2:0 |
| Fixed bank | 4 | bits 14:10 |
| Combined | 6 | fixed bank in bits 14:10, erasable bank in bits 2:0 |

A write to the combined register loads both banks in the same cycle. A read of any of the three returns the live bank values. A single superbank bit, taken from data bit 6 (counting from 0) of an I/O channel write, moves the four highest fixed banks (28 to 31) up to physical banks 32 to 35. That reaches the top 4K words of the 36-bank fixed store. The translation itself is combinational. The register writes take effect at the next rising clock edge.

Top module: `bank_xlate`

## Requirements
- R1: When addr_i[11:10] is 00 and addr_i[9:8] is not 11, fixed_sel_o is 0 and phys_addr_o equals addr_i, whatever the erasable bank is.
- R2: When addr_i[11:8] is 0011, fixed_sel_o is 0 and phys_addr_o is erasable bank * 256 + addr_i[7:0].
- R3: When addr_i[11:10] is 01 and no superbank remap applies, fixed_sel_o is 1 and phys_addr_o is fixed bank * 1024 + addr_i[9:0].
- R4: When addr_i[11] is 1, fixed_sel_o is 1 and phys_addr_o equals addr_i, whatever the fixed bank or superbank bit is.
- R5: With the superbank bit set, a fixed bank of 28 to 31 in the switched fixed window maps to physical bank (fixed bank + 4). Banks 0 to 27 are unaffected. The bit is loaded from chan_wdata_i[6] on a chan_we_i cycle and read back on sb_o.
- R6: A write to register address 6 loads the fixed bank from data bits 14:10 and the erasable bank from bits 2:0, both in the same clock edge.
- R7: Reading address 3 returns the erasable bank in bits 2:0. Reading address 4 returns the fixed bank in bits 14:10. Reading address 6 returns both fields at once. Writes to address 3 or 4 alone show up in the address 6 readback.
- R8: After reset, both bank registers and the superbank bit are 0.
- R9: A write to any register address other than 3, 4 or 6 changes no bank register. A read of those other addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Operand address to translate |
| reg_we_i | input | 1 | Bank register write strobe |
| reg_addr_i | input | 3 | Bank register write address |
| reg_wdata_i | input | 15 | Bank register write data |
| chan_we_i | input | 1 | I/O channel write strobe carrying the superbank bit |
| chan_wdata_i | input | 15 | Channel write data, bit 6 is the superbank bit |
| rd_addr_i | input | 3 | Bank register read address |
| rd_data_o | output | 15 | Bank register read data |
| sb_o | output | 1 | Current superbank bit |
| fixed_sel_o | output | 1 | 1 selects fixed memory, 0 selects erasable |
| phys_addr_o | output | 16 | Physical word address in the selected memory |

## Verification
The bench sweeps every one of the 4096 operand addresses under 32 fixed-bank values, each paired with an erasable bank and with the superbank bit both clear and set. The bank-window boundaries at 0x2FF/0x300, 0x3FF/0x400 and 0x7FF/0x800 are therefore all crossed under every bank setting. A design that let the erasable bank leak into the unswitched banks, or the fixed bank into the direct region, would miscompare across a whole region. A design that compared the remap against the wrong bank range would miss banks 28 to 31 or corrupt bank 27. Directed writes to the single registers and to unused addresses catch a combined readback with swapped fields and a decoder that aliases stray addresses onto a bank register.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W  = 12;
  localparam int WORD_W  = 15;
  localparam int EB_W    = 3;
  localparam int FB_W    = 5;
  localparam int EOFF_W  = 8;
  localparam int FOFF_W  = 10;
  localparam int PHYS_W  = FB_W + 1 + FOFF_W;
  localparam int RA_W    = 3;
  localparam int SB_IDX  = 6;

  typedef enum logic [RA_W-1:0] {
    RA_EBANK = 3'd3,
    RA_FBANK = 3'd4,
    RA_BOTH  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int EBW = EB_W,
  parameter int FBW = FB_W,
  parameter int SBI = SB_IDX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic [W-1:0]    reg_wdata_i,
  input  logic            chan_we_i,
  input  logic [W-1:0]    chan_wdata_i,
  input  logic [RA_W-1:0] rd_addr_i,
  output logic [W-1:0]    rd_data_o,
  output logic [EBW-1:0]  ebank_o,
  output logic [FBW-1:0]  fbank_o,
  output logic            sb_o
);
  localparam int FB_LO = W - FBW;

  logic [EBW-1:0] ebank_q;
  logic [FBW-1:0] fbank_q;
  logic           sb_q;
  logic           eb_hit, fb_hit;

  assign eb_hit = reg_we_i && (reg_addr_i == RA_EBANK || reg_addr_i == RA_BOTH);
  assign fb_hit = reg_we_i && (reg_addr_i == RA_FBANK || reg_addr_i == RA_BOTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ebank_q <= '0;
      fbank_q <= '0;
      sb_q    <= 1'b0;
    end else begin
      if (eb_hit)    ebank_q <= reg_wdata_i[EBW-1:0];
      if (fb_hit)    fbank_q <= reg_wdata_i[W-1:FB_LO];
      if (chan_we_i) sb_q    <= chan_wdata_i[SBI];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_EBANK: rd_data_o[EBW-1:0] = ebank_q;
      RA_FBANK: rd_data_o[W-1:FB_LO] = fbank_q;
      RA_BOTH: begin
        rd_data_o[EBW-1:0]   = ebank_q;
        rd_data_o[W-1:FB_LO] = fbank_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign ebank_o = ebank_q;
  assign fbank_o = fbank_q;
  assign sb_o    = sb_q;

  p_both_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_BOTH) |=>
      (fbank_q == $past(reg_wdata_i[W-1:FB_LO]) && ebank_q == $past(reg_wdata_i[EBW-1:0])));

  p_stray_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i != RA_EBANK && reg_addr_i != RA_FBANK && reg_addr_i != RA_BOTH)
      |=> ($stable(ebank_q) && $stable(fbank_q)));

  p_sb_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_we_i |=> (sb_q == $past(chan_wdata_i[SBI])));

  p_sb_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_we_i |=> $stable(sb_q));
endmodule

// File: rtl/addr_map.sv
module addr_map
  import bank_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int EBW = EB_W,
  parameter int FBW = FB_W,
  parameter int EOW = EOFF_W,
  parameter int FOW = FOFF_W,
  parameter int PW  = PHYS_W
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [EBW-1:0] ebank_i,
  input  logic [FBW-1:0] fbank_i,
  input  logic           sb_i,
  output logic           fixed_sel_o,
  output logic [PW-1:0]  phys_o
);
  localparam int BW = FBW + 1;

  logic [1:0]    region;
  logic [1:0]    esub;
  logic          remap;
  logic [BW-1:0] fbank_eff;

  assign region = addr_i[AW-1:AW-2];
  assign esub   = addr_i[FOW-1:EOW];

  // top four fixed banks move past the 5-bit range when the superbank bit is set
  assign remap     = sb_i && (&fbank_i[FBW-1:2]);
  assign fbank_eff = remap ? {1'b1, {(FBW-2){1'b0}}, fbank_i[1:0]} : {1'b0, fbank_i};

  always_comb begin
    fixed_sel_o = 1'b1;
    phys_o      = '0;
    unique case (region)
      2'b00: begin
        fixed_sel_o = 1'b0;
        if (esub == 2'b11) phys_o = {{(PW-EBW-EOW){1'b0}}, ebank_i, addr_i[EOW-1:0]};
        else               phys_o = {{(PW-FOW){1'b0}}, addr_i[FOW-1:0]};
      end
      2'b01:   phys_o = {fbank_eff, addr_i[FOW-1:0]};
      default: phys_o = {{(PW-AW){1'b0}}, addr_i};
    endcase
  end

  always_comb begin
    if (!fixed_sel_o) p_erasable_range_r2: assert (phys_o < (PW'(1) << (EBW + EOW)));
    if (region[1])    p_direct_bank_r4: assert (phys_o[PW-1:FOW] == PW'(addr_i[AW-1:FOW]));
    if (region == 2'b01 && sb_i)
      p_no_low_alias_r5: assert (phys_o[PW-1:FOW] < PW'(28) || phys_o[PW-1:FOW] >= PW'(32));
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              chan_we_i,
  input  logic [WORD_W-1:0] chan_wdata_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              sb_o,
  output logic              fixed_sel_o,
  output logic [PHYS_W-1:0] phys_addr_o
);
  logic [EB_W-1:0] ebank;
  logic [FB_W-1:0] fbank;
  logic            sb;

  bank_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .chan_we_i    (chan_we_i),
    .chan_wdata_i (chan_wdata_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .ebank_o      (ebank),
    .fbank_o      (fbank),
    .sb_o         (sb)
  );

  addr_map u_map (
    .addr_i      (addr_i),
    .ebank_i     (ebank),
    .fbank_i     (fbank),
    .sb_i        (sb),
    .fixed_sel_o (fixed_sel_o),
    .phys_o      (phys_addr_o)
  );

  assign sb_o = sb;

  p_switched_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[11:10] == 2'b01 && !sb) |-> (phys_addr_o[PHYS_W-1:FOFF_W] == {1'b0, fbank}));
endmodule

// File: tb/bank_xlate_test.sv
module bank_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [14:0] reg_wdata_i = '0;
  logic        chan_we_i = 1'b0;
  logic [14:0] chan_wdata_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [14:0] rd_data_o;
  logic        sb_o;
  logic        fixed_sel_o;
  logic [15:0] phys_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bank_xlate uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = 15'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wr_chan(input int d);
    @(negedge clk_i);
    chan_we_i = 1'b1; chan_wdata_i = 15'(d);
    @(negedge clk_i);
    chan_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    rd_addr_i = 3'(a);
    #1;
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic sweep(input int eb, input int fb, input bit sb);
    for (int a = 0; a < 4096; a++) begin
      int exp_p;
      int exp_f;
      string tag;
      addr_i = 12'(a);
      #1;
      if (a < 1024) begin
        exp_f = 0;
        if (a >= 768) begin exp_p = eb * 256 + a % 256; tag = "R2"; end
        else begin exp_p = a; tag = "R1"; end
      end else if (a < 2048) begin
        exp_f = 1;
        if (sb && fb >= 28) begin exp_p = (fb + 4) * 1024 + a % 1024; tag = "R5"; end
        else begin exp_p = fb * 1024 + a % 1024; tag = "R3"; end
      end else begin
        exp_f = 1; exp_p = a; tag = "R4";
      end
      chk(tag, {fixed_sel_o, phys_addr_o}, exp_f * 65536 + exp_p);
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    // R8 reset state
    rd("R8", 6, 0);
    chk("R8", int'(sb_o), 0);
    addr_i = 12'h7FF; #1;
    chk("R8", int'(phys_addr_o), 12'h3FF);

    // R7 single-register writes seen in combined readback
    wr_reg(3, 5);
    rd("R7", 3, 5);
    rd("R7", 6, 5);
    wr_reg(4, 19 << 10);
    rd("R7", 4, 19 << 10);
    rd("R7", 6, (19 << 10) | 5);
    wr_reg(3, 2);
    rd("R7", 6, (19 << 10) | 2);

    // R9 stray writes ignored, stray reads zero
    for (int a = 0; a < 8; a++) begin
      if (a != 3 && a != 4 && a != 6) begin
        wr_reg(a, 15'h7FFF);
        rd("R9", 6, (19 << 10) | 2);
        rd("R9", a, 0);
      end
    end

    // R5 superbank bit load from channel bit 6 only
    wr_chan(15'h7FBF);
    chk("R5", int'(sb_o), 0);
    wr_chan(15'h0040);
    chk("R5", int'(sb_o), 1);
    wr_chan(0);
    chk("R5", int'(sb_o), 0);

    // R6 combined write plus full address sweeps
    for (int s = 0; s < 2; s++) begin
      wr_chan(s << 6);
      for (int fb = 0; fb < 32; fb++) begin
        int eb;
        eb = (fb * 3 + s) % 8;
        wr_reg(6, (fb << 10) | eb);
        rd("R6", 4, fb << 10);
        rd("R6", 3, eb);
        sweep(eb, fb, bit'(s));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule